// File: doc/BRIEF.md
# Memory Dependency Group Tracker

This block keeps a fixed table of memory dependency groups for an out-of-order scheduler model. A group collects memory operations that share the same set of memory dependencies and do not depend on one another. For every group, the tracker counts how many predecessor groups it has and how far those predecessors have progressed. It also counts its own members and how many of them have issued and completed. From these counts it reports five status flags per group: waiting, pending, ready, executing and executed.

Links between groups come in two kinds. An order link is released as soon as every member of the source group has issued. A data link is released only when every member of the source group has finished. Each group remembers its issued member with the longest remaining latency. When the group starts executing, it forwards that latency to its data successors as a critical-path estimate. While a successor is still waiting on predecessors it has not heard from, that estimate counts down by one each clock.

Only one event enters per clock, and it is applied in that same cycle. An event that breaks the tracking rules is refused: every counter is left unchanged and the error output is raised.

Top module: `memdep_tracker`

## Requirements
- R1: The flags are derived from the predecessor counts. A group is waiting when its predecessor count exceeds the sum of its executing and executed predecessors. It is pending when the executing-predecessor count is nonzero and that sum equals the predecessor count. It is ready when the executed-predecessor count equals the predecessor count.
- R2: The flags are also derived from the member counts. A group is executing when its issued count is nonzero and equals its member count minus its completed count. It is executed when its completed count equals its member count.
- R3: The event code is 0 for add-member, 1 for add-link, 2 for issue and 3 for complete. Add-member raises the member count of the group. It is refused if the group already has any successor, or if the member count is at its maximum.
- R4: Add-link raises the predecessor count of the destination and records the link as order or data. An order link from a group that is already executing is silently ignored, with no error and no change.
- R5: A data link from a group that is already executing makes the destination count that predecessor as executing at once. The destination's critical estimate is raised to the source's critical latency if that value is larger.
- R6: The issue that makes a group executing does two things. Every order successor moves one predecessor straight to executed. Every data successor gains one executing predecessor and takes the larger of its critical estimate and the source's critical latency.
- R7: The completion of a group's last member moves one predecessor of every data successor from executing to executed.
- R8: The critical latency of a group is the largest latency among its issued members. If that member completes, the record is cleared, and later issues rebuild it.
- R9: Every cycle, a group that is waiting and has a nonzero critical estimate decrements that estimate. A group that is not waiting keeps its estimate unchanged.
- R10: The following events are refused, leaving all counts unchanged and raising the error output one cycle later for one cycle:
  - an issue to a group with no unissued member;
  - a completion to a group that is not ready or has no issued member;
  - an add-link that is a self link, a duplicate, from an executed group, or to a destination whose predecessor count is at its maximum;
  - an out-of-range index.
- R11: After reset every group is empty, ready and executed, with all other flags clear, every critical estimate zero and the error output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | An event is presented this cycle |
| ev_kind | input | 2 | Event code (0 add-member, 1 add-link, 2 issue, 3 complete) |
| ev_grp | input | IDX_W | Group the event applies to (link source for add-link) |
| ev_dst | input | IDX_W | Destination group of an add-link |
| ev_data | input | 1 | Add-link is a data link when high, order link when low |
| ev_id | input | ID_W | Member identifier for issue and complete |
| ev_lat | input | CYC_W | Remaining latency of the issuing member |
| grp_waiting | output | NG | Per-group waiting flag |
| grp_pending | output | NG | Per-group pending flag |
| grp_ready | output | NG | Per-group ready flag |
| grp_executing | output | NG | Per-group executing flag |
| grp_executed | output | NG | Per-group executed flag |
| crit_cyc | output | NG*CYC_W | Per-group critical estimate, group i at bits i*CYC_W upward |
| ev_err | output | 1 | Previous cycle's event was refused |

## Verification
The bench builds the tracker with four groups, 3-bit counters and 4-bit latencies. With these widths the member-count ceiling of seven is hit after a few events. Every group's flags and estimate can be checked after each step. Narrow latencies keep the countdown of a waiting group short enough to watch reach zero and stop there.

// File: rtl/memdep_pkg.sv
package memdep_pkg;
    typedef enum logic [1:0] {
        EV_ADD_INST = 2'd0,
        EV_ADD_SUCC = 2'd1,
        EV_ISSUE    = 2'd2,
        EV_EXEC     = 2'd3
    } ev_kind_e;
endpackage

// File: rtl/mdg_flags.sv
module mdg_flags #(
    parameter int CNT_W = 8
) (
    input  logic [CNT_W-1:0] npred,
    input  logic [CNT_W-1:0] pexec,
    input  logic [CNT_W-1:0] pdone,
    input  logic [CNT_W-1:0] ninst,
    input  logic [CNT_W-1:0] nissue,
    input  logic [CNT_W-1:0] ndone,
    output logic             waiting,
    output logic             pending,
    output logic             ready,
    output logic             executing,
    output logic             executed
);
    logic [CNT_W:0] psum;

    always_comb begin
        psum      = {1'b0, pexec} + {1'b0, pdone};
        waiting   = {1'b0, npred} > psum;
        pending   = (pexec != '0) && (psum == {1'b0, npred});
        ready     = (pdone == npred);
        executing = (nissue != '0) && (nissue == (ninst - ndone));
        executed  = (ninst == ndone);
    end
endmodule

// File: rtl/mdg_legal.sv
module mdg_legal
    import memdep_pkg::*;
(
    input  ev_kind_e kind,
    input  logic     data,
    input  logic     grp_ok,
    input  logic     dst_ok,
    input  logic     self_ref,
    input  logic     dup,
    input  logic     src_has_succ,
    input  logic     src_inst_full,
    input  logic     dst_pred_full,
    input  logic     src_can_issue,
    input  logic     src_ready,
    input  logic     src_busy,
    input  logic     src_executing,
    input  logic     src_executed,
    output logic     legal,
    output logic     noop
);
    always_comb begin
        legal = 1'b0;
        noop  = 1'b0;
        if (grp_ok) begin
            unique case (kind)
                EV_ADD_INST: legal = !src_has_succ && !src_inst_full;
                EV_ADD_SUCC: begin
                    if (!dst_ok) begin
                        legal = 1'b0;
                    end else if (!data && src_executing) begin
                        legal = 1'b1;
                        noop  = 1'b1;
                    end else begin
                        legal = !self_ref && !dup && !src_executed && !dst_pred_full;
                    end
                end
                EV_ISSUE:    legal = src_can_issue;
                EV_EXEC:     legal = src_ready && src_busy;
                default:     legal = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/memdep_tracker.sv
module memdep_tracker
    import memdep_pkg::*;
#(
    parameter int NG    = 16,
    parameter int CNT_W = 8,
    parameter int CYC_W = 8,
    parameter int ID_W  = 8,
    parameter int IDX_W = (NG > 1) ? $clog2(NG) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ev_valid,
    input  logic [1:0]          ev_kind,
    input  logic [IDX_W-1:0]    ev_grp,
    input  logic [IDX_W-1:0]    ev_dst,
    input  logic                ev_data,
    input  logic [ID_W-1:0]     ev_id,
    input  logic [CYC_W-1:0]    ev_lat,
    output logic [NG-1:0]       grp_waiting,
    output logic [NG-1:0]       grp_pending,
    output logic [NG-1:0]       grp_ready,
    output logic [NG-1:0]       grp_executing,
    output logic [NG-1:0]       grp_executed,
    output logic [NG*CYC_W-1:0] crit_cyc,
    output logic                ev_err
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [CYC_W-1:0] CYC_ONE = CYC_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] npred;
        logic [CNT_W-1:0] pexec;
        logic [CNT_W-1:0] pdone;
        logic [CNT_W-1:0] ninst;
        logic [CNT_W-1:0] nissue;
        logic [CNT_W-1:0] ndone;
        logic [NG-1:0]    osucc;
        logic [NG-1:0]    dsucc;
        logic             cvalid;
        logic [ID_W-1:0]  cid;
        logic [CYC_W-1:0] clat;
        logic [CYC_W-1:0] ccyc;
    } grp_t;

    grp_t st_q [NG];
    grp_t st_d [NG];
    logic err_q, err_d;

    // per-group status decode
    logic [NG-1:0] f_wait, f_pend, f_rdy, f_exing, f_exed;

    for (genvar i = 0; i < NG; i++) begin : g_flags
        mdg_flags #(.CNT_W(CNT_W)) u_flags (
            .npred     (st_q[i].npred),
            .pexec     (st_q[i].pexec),
            .pdone     (st_q[i].pdone),
            .ninst     (st_q[i].ninst),
            .nissue    (st_q[i].nissue),
            .ndone     (st_q[i].ndone),
            .waiting   (f_wait[i]),
            .pending   (f_pend[i]),
            .ready     (f_rdy[i]),
            .executing (f_exing[i]),
            .executed  (f_exed[i])
        );
        assign crit_cyc[i*CYC_W +: CYC_W] = st_q[i].ccyc;
    end

    // event decode
    ev_kind_e         kind;
    logic             grp_ok, dst_ok;
    logic [IDX_W-1:0] gsi, dsi;
    grp_t             src, dsg;
    logic             legal, noop;

    always_comb begin
        kind   = ev_kind_e'(ev_kind);
        grp_ok = (int'(ev_grp) < NG);
        dst_ok = (int'(ev_dst) < NG);
        gsi    = grp_ok ? ev_grp : '0;
        dsi    = dst_ok ? ev_dst : '0;
        src    = st_q[gsi];
        dsg    = st_q[dsi];
    end

    mdg_legal u_legal (
        .kind          (kind),
        .data          (ev_data),
        .grp_ok        (grp_ok),
        .dst_ok        (dst_ok),
        .self_ref      (gsi == dsi),
        .dup           (src.osucc[dsi] | src.dsucc[dsi]),
        .src_has_succ  ((|src.osucc) | (|src.dsucc)),
        .src_inst_full (&src.ninst),
        .dst_pred_full (&dsg.npred),
        .src_can_issue (src.nissue < (src.ninst - src.ndone)),
        .src_ready     (f_rdy[gsi]),
        .src_busy      (src.nissue != '0),
        .src_executing (f_exing[gsi]),
        .src_executed  (f_exed[gsi]),
        .legal         (legal),
        .noop          (noop)
    );

    // next-state computation
    always_comb begin
        for (int i = 0; i < NG; i++) begin
            st_d[i] = st_q[i];
            if (f_wait[i] && (st_q[i].ccyc != '0)) begin
                st_d[i].ccyc = st_q[i].ccyc - CYC_ONE;
            end
        end
        err_d = 1'b0;

        if (ev_valid) begin
            if (!legal) begin
                err_d = 1'b1;
            end else begin
                unique case (kind)
                    EV_ADD_INST: st_d[gsi].ninst = src.ninst + CNT_ONE;
                    EV_ADD_SUCC: begin
                        if (!noop) begin
                            st_d[dsi].npred = dsg.npred + CNT_ONE;
                            if (ev_data) st_d[gsi].dsucc[dsi] = 1'b1;
                            else         st_d[gsi].osucc[dsi] = 1'b1;
                            if (f_exing[gsi]) begin
                                st_d[dsi].pexec = dsg.pexec + CNT_ONE;
                                if (ev_data && src.cvalid && (src.clat > st_d[dsi].ccyc)) begin
                                    st_d[dsi].ccyc = src.clat;
                                end
                            end
                        end
                    end
                    EV_ISSUE: begin
                        st_d[gsi].nissue = src.nissue + CNT_ONE;
                        if (!src.cvalid || (src.clat < ev_lat)) begin
                            st_d[gsi].cvalid = 1'b1;
                            st_d[gsi].cid    = ev_id;
                            st_d[gsi].clat   = ev_lat;
                        end
                        if ((src.nissue + CNT_ONE) == (src.ninst - src.ndone)) begin
                            for (int s = 0; s < NG; s++) begin
                                if (src.osucc[s]) begin
                                    st_d[s].pdone = st_q[s].pdone + CNT_ONE;
                                end
                                if (src.dsucc[s]) begin
                                    st_d[s].pexec = st_q[s].pexec + CNT_ONE;
                                    if (st_d[gsi].clat > st_d[s].ccyc) begin
                                        st_d[s].ccyc = st_d[gsi].clat;
                                    end
                                end
                            end
                        end
                    end
                    EV_EXEC: begin
                        st_d[gsi].nissue = src.nissue - CNT_ONE;
                        st_d[gsi].ndone  = src.ndone + CNT_ONE;
                        if (src.cvalid && (src.cid == ev_id)) begin
                            st_d[gsi].cvalid = 1'b0;
                        end
                        if ((src.ndone + CNT_ONE) == src.ninst) begin
                            for (int s = 0; s < NG; s++) begin
                                if (src.dsucc[s]) begin
                                    st_d[s].pexec = st_q[s].pexec - CNT_ONE;
                                    st_d[s].pdone = st_q[s].pdone + CNT_ONE;
                                end
                            end
                        end
                    end
                    default: err_d = 1'b1;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NG; i++) st_q[i] <= '0;
            err_q <= 1'b0;
        end else begin
            for (int i = 0; i < NG; i++) st_q[i] <= st_d[i];
            err_q <= err_d;
        end
    end

    assign grp_waiting   = f_wait;
    assign grp_pending   = f_pend;
    assign grp_ready     = f_rdy;
    assign grp_executing = f_exing;
    assign grp_executed  = f_exed;
    assign ev_err        = err_q;
endmodule

// File: rtl/memdep_tracker_chk.sv
module memdep_tracker_chk
    import memdep_pkg::*;
#(
    parameter int NG    = 16,
    parameter int CYC_W = 8,
    parameter int IDX_W = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                ev_valid,
    input logic [1:0]          ev_kind,
    input logic [IDX_W-1:0]    ev_grp,
    input logic [IDX_W-1:0]    ev_dst,
    input logic                ev_err,
    input logic [NG-1:0]       grp_waiting,
    input logic [NG-1:0]       grp_pending,
    input logic [NG-1:0]       grp_ready,
    input logic [NG-1:0]       grp_executing,
    input logic [NG-1:0]       grp_executed,
    input logic [NG*CYC_W-1:0] crit_cyc
);
    // refused event leaves every flag as it was (R10)
    p_err_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ev_err |-> (grp_waiting == $past(grp_waiting) && grp_pending == $past(grp_pending) &&
                    grp_ready == $past(grp_ready) && grp_executing == $past(grp_executing) &&
                    grp_executed == $past(grp_executed)));

    for (genvar g = 0; g < NG; g++) begin : g_chk
        // readiness is only lost when a new predecessor link arrives (R4)
        p_ready_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(grp_ready[g]) |-> $past(ev_valid && ev_kind == 2'(EV_ADD_SUCC) && ev_dst == IDX_W'(g)));

        // a finished group reopens only by receiving a member (R3)
        p_executed_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(grp_executed[g]) |-> $past(ev_valid && ev_kind == 2'(EV_ADD_INST) && ev_grp == IDX_W'(g)));

        // a group starts executing only through its own issue event (R6)
        p_exec_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(grp_executing[g]) |-> $past(ev_valid && ev_kind == 2'(EV_ISSUE) && ev_grp == IDX_W'(g)));

        // the critical estimate only grows on link or issue events (R9)
        p_crit_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (crit_cyc[g*CYC_W +: CYC_W] > $past(crit_cyc[g*CYC_W +: CYC_W])) |->
            $past(ev_valid && (ev_kind == 2'(EV_ADD_SUCC) || ev_kind == 2'(EV_ISSUE))));
    end
endmodule

bind memdep_tracker memdep_tracker_chk #(
    .NG    (NG),
    .CYC_W (CYC_W),
    .IDX_W (IDX_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ev_valid      (ev_valid),
    .ev_kind       (ev_kind),
    .ev_grp        (ev_grp),
    .ev_dst        (ev_dst),
    .ev_err        (ev_err),
    .grp_waiting   (grp_waiting),
    .grp_pending   (grp_pending),
    .grp_ready     (grp_ready),
    .grp_executing (grp_executing),
    .grp_executed  (grp_executed),
    .crit_cyc      (crit_cyc)
);

// File: tb/sim_memdep_tracker.sv
`timescale 1ns/1ps
module sim_memdep_tracker;
    localparam int NG    = 4;
    localparam int CNT_W = 3;
    localparam int CYC_W = 4;
    localparam int ID_W  = 4;
    localparam int IDX_W = 2;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic                rst_n = 1'b0;
    logic                ev_valid = 1'b0;
    logic [1:0]          ev_kind = '0;
    logic [IDX_W-1:0]    ev_grp = '0;
    logic [IDX_W-1:0]    ev_dst = '0;
    logic                ev_data = 1'b0;
    logic [ID_W-1:0]     ev_id = '0;
    logic [CYC_W-1:0]    ev_lat = '0;
    logic [NG-1:0]       grp_waiting, grp_pending, grp_ready, grp_executing, grp_executed;
    logic [NG*CYC_W-1:0] crit_cyc;
    logic                ev_err;

    memdep_tracker #(.NG(NG), .CNT_W(CNT_W), .CYC_W(CYC_W), .ID_W(ID_W)) u0 (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind),
        .ev_grp(ev_grp), .ev_dst(ev_dst), .ev_data(ev_data), .ev_id(ev_id),
        .ev_lat(ev_lat), .grp_waiting(grp_waiting), .grp_pending(grp_pending),
        .grp_ready(grp_ready), .grp_executing(grp_executing),
        .grp_executed(grp_executed), .crit_cyc(crit_cyc), .ev_err(ev_err)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int crit(input int g);
        return int'(crit_cyc[g*CYC_W +: CYC_W]);
    endfunction

    task automatic ev(input int k, input int g, input int d, input bit data, input int id, input int lat);
        @(negedge clk);
        ev_valid = 1'b1;
        ev_kind  = 2'(k);
        ev_grp   = IDX_W'(g);
        ev_dst   = IDX_W'(d);
        ev_data  = data;
        ev_id    = ID_W'(id);
        ev_lat   = CYC_W'(lat);
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    task automatic add_inst(input int g);                   ev(0, g, 0, 1'b0, 0, 0);    endtask
    task automatic add_link(input int g, input int d, input bit data); ev(1, g, d, data, 0, 0); endtask
    task automatic issue(input int g, input int id, input int lat); ev(2, g, 0, 1'b0, id, lat); endtask
    task automatic complete(input int g, input int id);     ev(3, g, 0, 1'b0, id, 0);   endtask
    task automatic idle(input int n); repeat (n) @(negedge clk); endtask

    task automatic do_reset();
        ev_valid = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        for (int g = 0; g < NG; g++) begin
            chk("R11", "ready after reset", int'(grp_ready[g]), 1);
            chk("R11", "executed after reset", int'(grp_executed[g]), 1);
            chk("R11", "waiting after reset", int'(grp_waiting[g]), 0);
            chk("R11", "pending after reset", int'(grp_pending[g]), 0);
            chk("R11", "executing after reset", int'(grp_executing[g]), 0);
            chk("R11", "crit after reset", crit(g), 0);
        end
        chk("R11", "err after reset", int'(ev_err), 0);
    endtask

    task automatic t_order();
        do_reset();
        add_inst(0); add_inst(0);
        chk("R2", "g0 not executed with members", int'(grp_executed[0]), 0);
        add_link(0, 1, 1'b0);
        chk("R1", "g1 waiting on order link", int'(grp_waiting[1]), 1);
        chk("R4", "g1 not ready after link", int'(grp_ready[1]), 0);
        issue(0, 1, 3);
        chk("R2", "g0 not executing, one left", int'(grp_executing[0]), 0);
        chk("R6", "g1 still waiting", int'(grp_waiting[1]), 1);
        issue(0, 2, 4);
        chk("R2", "g0 executing", int'(grp_executing[0]), 1);
        chk("R6", "g1 ready on order release", int'(grp_ready[1]), 1);
        chk("R6", "g1 not pending", int'(grp_pending[1]), 0);
        add_link(0, 2, 1'b0);
        chk("R4", "late order link no error", int'(ev_err), 0);
        chk("R4", "late order link leaves g2 ready", int'(grp_ready[2]), 1);
        add_inst(0);
        chk("R3", "member add after link refused", int'(ev_err), 1);
        chk("R3", "g0 still executing", int'(grp_executing[0]), 1);
        complete(0, 1);
        chk("R2", "g0 executing after one done", int'(grp_executing[0]), 1);
        complete(0, 2);
        chk("R2", "g0 executed", int'(grp_executed[0]), 1);
        chk("R2", "g0 no longer executing", int'(grp_executing[0]), 0);
    endtask

    task automatic t_data();
        do_reset();
        add_inst(0);
        add_link(0, 1, 1'b1);
        chk("R4", "g1 waiting on data link", int'(grp_waiting[1]), 1);
        issue(0, 1, 5);
        chk("R6", "g1 pending", int'(grp_pending[1]), 1);
        chk("R1", "g1 not waiting", int'(grp_waiting[1]), 0);
        chk("R6", "g1 crit from source", crit(1), 5);
        idle(3);
        chk("R9", "pending crit held", crit(1), 5);
        complete(0, 1);
        chk("R7", "g1 ready after source done", int'(grp_ready[1]), 1);
        chk("R7", "g1 not pending", int'(grp_pending[1]), 0);
    endtask

    task automatic t_late_link();
        do_reset();
        add_inst(0); add_inst(0);
        issue(0, 1, 4);
        issue(0, 2, 8);
        add_link(0, 1, 1'b1);
        chk("R5", "late data link pending", int'(grp_pending[1]), 1);
        chk("R8", "crit is largest latency", crit(1), 8);
        add_link(0, 2, 1'b0);
        chk("R4", "late order link no error", int'(ev_err), 0);
        chk("R4", "g2 ready kept", int'(grp_ready[2]), 1);
        chk("R4", "g2 not waiting", int'(grp_waiting[2]), 0);
    endtask

    task automatic t_crit();
        do_reset();
        add_inst(0); add_inst(0); add_inst(0);
        add_inst(3);
        add_link(0, 1, 1'b1);
        add_link(3, 1, 1'b1);
        issue(0, 1, 9);
        complete(0, 1);
        issue(0, 2, 3);
        issue(0, 3, 2);
        chk("R8", "cleared record rebuilt", crit(1), 3);
        chk("R1", "g1 waiting on g3", int'(grp_waiting[1]), 1);
        idle(2);
        chk("R9", "waiting crit counts down", crit(1), 1);
        idle(2);
        chk("R9", "countdown stops at zero", crit(1), 0);
    endtask

    task automatic t_illegal();
        do_reset();
        issue(0, 1, 1);
        chk("R10", "issue to empty refused", int'(ev_err), 1);
        chk("R10", "g0 still executed", int'(grp_executed[0]), 1);
        complete(0, 0);
        chk("R10", "complete with none issued", int'(ev_err), 1);
        add_inst(0);
        add_link(0, 1, 1'b1);
        add_inst(1);
        complete(1, 0);
        chk("R10", "complete while not ready", int'(ev_err), 1);
        issue(1, 4, 2);
        chk("R10", "issue while waiting allowed", int'(ev_err), 0);
        complete(1, 4);
        chk("R10", "complete of unready group", int'(ev_err), 1);
        chk("R10", "g1 still executing", int'(grp_executing[1]), 1);
        add_inst(2);
        add_link(2, 2, 1'b0);
        chk("R10", "self link refused", int'(ev_err), 1);
        chk("R10", "g2 still ready", int'(grp_ready[2]), 1);
        add_link(0, 1, 1'b1);
        chk("R10", "duplicate link refused", int'(ev_err), 1);
        issue(0, 1, 1);
        complete(0, 1);
        chk("R10", "g1 ready, duplicate not counted", int'(grp_ready[1]), 1);
        add_link(0, 3, 1'b1);
        chk("R10", "link from executed refused", int'(ev_err), 1);
        for (int i = 0; i < 7; i++) add_inst(3);
        chk("R3", "seventh member accepted", int'(ev_err), 0);
        add_inst(3);
        chk("R3", "member count full refused", int'(ev_err), 1);
        idle(1);
        chk("R10", "error lasts one cycle", int'(ev_err), 0);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_order();
        t_data();
        t_late_link();
        t_crit();
        t_illegal();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule